// File: doc/BRIEF.md
# Stimulus-Port Trace Serializer

This block lets software emit trace data over one output wire. Software writes a byte, halfword or word to any of 32 stimulus port registers. An accepted write becomes a packet: a header byte that carries the port number and the payload size, followed by the payload bytes. Packets wait in a small FIFO. They then leave on `trace_out` as a UART-style NRZ stream. The bit period is set by a programmable divider of the core clock.

A bus slave holds the configuration registers. These are a lock register, a control register with a global enable and a sync enable, a per-port enable mask, a privilege word, a pin-protocol selector and a baud prescaler. A stimulus write leaves the block only when all of the following hold: the global enable is set, the port's mask bit is set, the protocol selector reads NRZ, and the FIFO has room. Reading a stimulus port returns 1 while a new write can be taken. Software polls that value before it writes. While sync is enabled and nothing else is pending, the block sends a periodic alignment packet so that a receiver can find byte boundaries.

Top module: `trace_wire_tx`

## Requirements
- R1: An accepted stimulus write to port p is sent as a header byte {p[4:0], 1'b0, code[1:0]}, then the payload least significant byte first. The code is 01 for a byte access (bus_size 0, one payload byte), 10 for a halfword (bus_size 1, two bytes) and 11 for a word (bus_size 2, four bytes).
- R2: A stimulus write to a port whose bit in the enable mask (word index 33) is clear produces no output.
- R3: While bit 0 of the control register (word index 32) is clear, no stimulus write produces output.
- R4: Stimulus writes produce output only while the protocol register (word index 35) holds 2 (NRZ). Its reset value is 1.
- R5: Writing 0xC5ACCE55 to the lock register (word index 37) unlocks the block, and writing any other value relocks it. Reading the lock register returns 1 in bit 0 when unlocked. While locked, writes to word indices 32 to 36 are ignored.
- R6: Reading any stimulus port (word indices 0 to 31) returns 1 while the packet FIFO has space and 0 when it is full. A stimulus write made while the FIFO is full is discarded.
- R7: Each byte goes out as one low start bit, eight data bits LSB first and one high stop bit. The line idles high.
- R8: Every bit lasts prescaler+1 core clock cycles, where the prescaler is held at word index 36.
- R9: While control bit 1 (sync enable) is set, the FIFO is empty and the line is idle, the block sends the bytes 00 00 00 00 00 80 every SYNC_GAP idle cycles.
- R10: After reset the line is high, the block is locked, and the control register and enable mask read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| trace_out | output | 1 | NRZ serial trace line |

## Verification
The bench builds the block with a four-entry FIFO, a 12-bit prescaler and SYNC_GAP set to 100. With these values, filling the FIFO while one packet is on the wire, and seeing the ready flag drop, takes only a few bus writes. Alignment packets also appear within a few hundred cycles of idle. Running the prescaler at 3 and at 7 shows that the bit width follows the register, while the tests stay short.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int NPORT  = 32;
    localparam int PORT_W = $clog2(NPORT);

    localparam int REG_CTRL  = 32;
    localparam int REG_MASK  = 33;
    localparam int REG_PRIV  = 34;
    localparam int REG_PROTO = 35;
    localparam int REG_PRESC = 36;
    localparam int REG_LOCK  = 37;

    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
    localparam logic [1:0]  PROTO_MAN  = 2'd1;
    localparam logic [1:0]  PROTO_NRZ  = 2'd2;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [1:0]        code;
        logic [31:0]       data;
    } stim_t;
endpackage

// File: rtl/trace_regs.sv
module trace_regs
    import trace_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               fifo_full,
    output logic               push,
    output stim_t              push_item,
    output logic               ctrl_en,
    output logic               sync_en,
    output logic [NPORT-1:0]   port_mask,
    output logic               unlocked,
    output logic [PRESC_W-1:0] presc
);
    typedef struct packed {
        logic               unlocked;
        logic               en;
        logic               sync;
        logic [NPORT-1:0]   mask;
        logic [31:0]        priv;
        logic [1:0]         proto;
        logic [PRESC_W-1:0] presc;
    } regs_t;

    regs_t q, d;
    logic  is_stim;

    always_comb begin
        d         = q;
        push      = 1'b0;
        is_stim   = (bus_addr < ADDR_W'(NPORT));
        push_item.port = bus_addr[PORT_W-1:0];
        unique case (bus_size)
            2'd0:    begin push_item.code = 2'b01; push_item.data = {24'd0, bus_wdata[7:0]};  end
            2'd1:    begin push_item.code = 2'b10; push_item.data = {16'd0, bus_wdata[15:0]}; end
            default: begin push_item.code = 2'b11; push_item.data = bus_wdata;                end
        endcase

        if (bus_sel && bus_we) begin
            if (is_stim) begin
                if (q.en && q.proto == PROTO_NRZ && q.mask[bus_addr[PORT_W-1:0]] && !fifo_full)
                    push = 1'b1;
            end else if (bus_addr == ADDR_W'(REG_LOCK)) begin
                d.unlocked = (bus_wdata == UNLOCK_KEY);
            end else if (q.unlocked) begin
                if (bus_addr == ADDR_W'(REG_CTRL))  begin d.en = bus_wdata[0]; d.sync = bus_wdata[1]; end
                if (bus_addr == ADDR_W'(REG_MASK))  d.mask  = bus_wdata[NPORT-1:0];
                if (bus_addr == ADDR_W'(REG_PRIV))  d.priv  = bus_wdata;
                if (bus_addr == ADDR_W'(REG_PROTO)) d.proto = bus_wdata[1:0];
                if (bus_addr == ADDR_W'(REG_PRESC)) d.presc = bus_wdata[PRESC_W-1:0];
            end
        end

        bus_rdata = 32'd0;
        if (is_stim)                              bus_rdata = {31'd0, !fifo_full};
        else if (bus_addr == ADDR_W'(REG_CTRL))   bus_rdata = {30'd0, q.sync, q.en};
        else if (bus_addr == ADDR_W'(REG_MASK))   bus_rdata = q.mask;
        else if (bus_addr == ADDR_W'(REG_PRIV))   bus_rdata = q.priv;
        else if (bus_addr == ADDR_W'(REG_PROTO))  bus_rdata = {30'd0, q.proto};
        else if (bus_addr == ADDR_W'(REG_PRESC))  bus_rdata = 32'(q.presc);
        else if (bus_addr == ADDR_W'(REG_LOCK))   bus_rdata = {31'd0, q.unlocked};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.proto    <= PROTO_MAN;
        end else begin
            q <= d;
        end
    end

    assign ctrl_en   = q.en;
    assign sync_en   = q.sync;
    assign port_mask = q.mask;
    assign unlocked  = q.unlocked;
    assign presc     = q.presc;
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
    parameter int W     = 39,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [W-1:0]       wdata,
    input  logic               pop,
    output logic [W-1:0]       rdata,
    output logic               empty,
    output logic               full,
    output logic [CNT_W-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wr] = wdata;
            d.wr = (q.wr == PTR_W'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (do_pop)
            d.rd = (q.rd == PTR_W'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        d.cnt = q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign count = q.cnt;
endmodule

// File: rtl/trace_packer.sv
module trace_packer
    import trace_pkg::*;
#(
    parameter int SYNC_GAP = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  stim_t      fifo_item,
    output logic       fifo_pop,
    input  logic       sync_en,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       pk_busy
);
    localparam int SC_W = $clog2(SYNC_GAP + 1);
    localparam logic [47:0] SYNC_SEQ = 48'h80_00_00_00_00_00;

    typedef struct packed {
        logic            busy;
        logic [47:0]     bytes;
        logic [2:0]      left;
        logic [SC_W-1:0] scnt;
    } pk_t;

    pk_t q, d;

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        tx_valid = q.busy;
        tx_byte  = q.bytes[7:0];
        if (q.busy) begin
            if (tx_ready) begin
                d.bytes = {8'd0, q.bytes[47:8]};
                d.left  = q.left - 3'd1;
                if (q.left == 3'd1) d.busy = 1'b0;
            end
        end else if (!fifo_empty) begin
            fifo_pop = 1'b1;
            d.busy   = 1'b1;
            d.scnt   = '0;
            d.bytes  = {8'd0, fifo_item.data, fifo_item.port, 1'b0, fifo_item.code};
            unique case (fifo_item.code)
                2'b01:   d.left = 3'd2;
                2'b10:   d.left = 3'd3;
                default: d.left = 3'd5;
            endcase
        end else if (sync_en && tx_ready) begin
            if (q.scnt == SC_W'(SYNC_GAP - 1)) begin
                d.busy  = 1'b1;
                d.bytes = SYNC_SEQ;
                d.left  = 3'd6;
                d.scnt  = '0;
            end else begin
                d.scnt = q.scnt + 1'b1;
            end
        end else begin
            d.scnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pk_busy = q.busy;
endmodule

// File: rtl/trace_serial.sv
module trace_serial #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic               tx_valid,
    input  logic [7:0]         tx_byte,
    output logic               tx_ready,
    output logic               tx_busy,
    output logic               line
);
    typedef struct packed {
        logic               busy;
        logic [9:0]         shreg;
        logic [3:0]         bits;
        logic [PRESC_W-1:0] cnt;
        logic [PRESC_W-1:0] div;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (tx_valid) begin
                d.busy  = 1'b1;
                d.shreg = {1'b1, tx_byte, 1'b0};
                d.bits  = 4'd9;
                d.cnt   = presc;
                d.div   = presc;
            end
        end else if (q.cnt == '0) begin
            if (q.bits == 4'd0) begin
                d.busy = 1'b0;
            end else begin
                d.shreg = {1'b1, q.shreg[9:1]};
                d.bits  = q.bits - 4'd1;
                d.cnt   = q.div;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.shreg <= '1;
        end else begin
            q <= d;
        end
    end

    assign tx_ready = !q.busy;
    assign tx_busy  = q.busy;
    assign line     = q.shreg[0];
endmodule

// File: rtl/trace_wire_tx.sv
module trace_wire_tx
    import trace_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int PRESC_W    = 16,
    parameter int SYNC_GAP   = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              trace_out
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int ITEM_W = $bits(stim_t);

    logic               fifo_full, fifo_empty, push, pop;
    stim_t              push_item, head_item;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               ctrl_en, sync_en, unlocked;
    logic [NPORT-1:0]   port_mask;
    logic [PRESC_W-1:0] presc;
    logic               tx_valid, tx_ready, tx_busy, pk_busy;
    logic [7:0]         tx_byte;

    trace_regs #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_full(fifo_full), .push(push), .push_item(push_item),
        .ctrl_en(ctrl_en), .sync_en(sync_en), .port_mask(port_mask),
        .unlocked(unlocked), .presc(presc)
    );

    trace_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata(push_item), .pop(pop), .rdata(head_item),
        .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
    );

    trace_packer #(.SYNC_GAP(SYNC_GAP)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_item(head_item), .fifo_pop(pop),
        .sync_en(sync_en), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .pk_busy(pk_busy)
    );

    trace_serial #(.PRESC_W(PRESC_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .presc(presc),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .tx_busy(tx_busy), .line(trace_out)
    );
endmodule

// File: rtl/trace_wire_tx_chk.sv
module trace_wire_tx_chk
    import trace_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              trace_out,
    input logic              tx_busy,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              ctrl_en,
    input logic              unlocked,
    input logic [NPORT-1:0]  port_mask
);
    logic stim_wr;
    assign stim_wr = bus_sel && bus_we && (bus_addr < ADDR_W'(NPORT));

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> trace_out);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    // R2
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_wr && !port_mask[bus_addr[PORT_W-1:0]]) |=> (fifo_cnt <= $past(fifo_cnt)));

    // R3
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_wr && !ctrl_en) |=> (fifo_cnt <= $past(fifo_cnt)));

    // R5
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !unlocked && bus_addr == ADDR_W'(REG_CTRL)) |=> $stable(ctrl_en));
endmodule

bind trace_wire_tx trace_wire_tx_chk #(
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .trace_out(trace_out), .tx_busy(tx_busy),
    .fifo_cnt(fifo_cnt), .ctrl_en(ctrl_en), .unlocked(unlocked),
    .port_mask(port_mask)
);

// File: tb/sim_trace_wire_tx.sv
`timescale 1ns/1ps
module sim_trace_wire_tx;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          trace_out;

    int n_chk = 0, n_bad = 0;
    int bit_cyc = 4;

    always #2.5 clk = ~clk;

    trace_wire_tx #(.ADDR_W(AW), .FIFO_DEPTH(4), .PRESC_W(12), .SYNC_GAP(100)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .trace_out(trace_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int addr, input logic [1:0] sz, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_size = sz; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        #1 data = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, output bit ok);
        int t = 0;
        ok = 1'b0; b = 8'h00;
        while (trace_out !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) return;
        repeat (bit_cyc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bit_cyc) @(negedge clk);
            b[i] = trace_out;
        end
        repeat (bit_cyc) @(negedge clk);
        ok = (trace_out === 1'b1);
    endtask

    task automatic expect_bytes(input logic [47:0] exp, input int n, input string req);
        logic [7:0] b;
        bit ok;
        for (int i = 0; i < n; i++) begin
            get_byte(b, ok);
            check(ok && b == exp[i*8 +: 8], req, b, exp[i*8 +: 8]);
        end
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (trace_out !== 1'b1) lows++;
        end
        check(lows == 0, req, lows, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        check(trace_out === 1'b1, "R10 line idle", trace_out, 1);
        bus_rd(37, v); check(v == 0, "R10 locked", v, 0);
        bus_rd(32, v); check(v == 0, "R10 ctrl", v, 0);
        bus_rd(33, v); check(v == 0, "R10 mask", v, 0);
        bus_rd(5, v);  check(v == 1, "R6 ready", v, 1);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        bus_wr(32, 2'd2, 32'h1);
        bus_rd(32, v); check(v == 0, "R5 locked write ignored", v, 0);
        bus_wr(37, 2'd2, 32'hC5ACCE55);
        bus_rd(37, v); check(v == 1, "R5 unlocked", v, 1);
        bus_wr(35, 2'd2, 32'h2);
        bus_wr(36, 2'd2, 32'd3);
        bus_wr(33, 2'd2, 32'h8000_0005);
        bus_wr(32, 2'd2, 32'h1);
        bus_rd(32, v); check(v == 1, "R5 ctrl write taken", v, 1);
        bus_rd(33, v); check(v == 32'h8000_0005, "R5 mask write taken", v, 32'h8000_0005);
    endtask

    task automatic t_packets;
        // R1 R7: byte on port 0, half on port 2, word on port 31
        bus_wr(0, 2'd0, 32'hFFFF_FF41);
        expect_bytes(48'h41_01, 2, "R1 byte packet");
        bus_wr(2, 2'd1, 32'h1234_BEEF);
        expect_bytes(48'hBE_EF_12, 3, "R1 half packet");
        bus_wr(31, 2'd2, 32'h1234_5678);
        expect_bytes(48'h12_34_56_78_FB, 5, "R1 word packet");
    endtask

    task automatic t_gating;
        bus_wr(1, 2'd0, 32'h55);
        expect_quiet(200, "R2 masked port");
        bus_wr(32, 2'd2, 32'h0);
        bus_wr(0, 2'd0, 32'h55);
        expect_quiet(200, "R3 global off");
        bus_wr(32, 2'd2, 32'h1);
        bus_wr(35, 2'd2, 32'h1);
        bus_wr(0, 2'd0, 32'h55);
        expect_quiet(200, "R4 manchester selected");
        bus_wr(35, 2'd2, 32'h2);
    endtask

    task automatic measure_start(input int presc_val);
        int low = 0, t = 0;
        bus_wr(36, 2'd2, presc_val);
        bit_cyc = presc_val + 1;
        bus_wr(0, 2'd0, 32'hFF);
        while (trace_out !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
        while (trace_out === 1'b0 && low < 2000) begin @(negedge clk); low++; end
        check(low == presc_val + 1, "R8 bit width", low, presc_val + 1);
        repeat (25 * bit_cyc) @(negedge clk);
    endtask

    task automatic t_fifo_full;
        logic [31:0] v = '1;
        bit_cyc = 4;
        bus_wr(36, 2'd2, 32'd3);
        fork
            begin
                bus_wr(0, 2'd0, 32'h10);
                repeat (4) @(negedge clk);
                for (int k = 1; k <= 4; k++) bus_wr(0, 2'd0, 32'h10 + k);
                bus_rd(0, v);
                bus_wr(0, 2'd0, 32'h15);
            end
            begin
                for (int k = 0; k <= 4; k++)
                    expect_bytes({40'd0, 8'h10 + 8'(k)} << 8 | 48'h01, 2, "R6 queued packet");
            end
        join
        check(v == 0, "R6 ready low when full", v, 0);
        expect_quiet(200, "R6 write while full dropped");
    endtask

    task automatic t_sync;
        logic [31:0] v;
        bus_wr(32, 2'd2, 32'h3);
        expect_bytes(48'h80_00_00_00_00_00, 6, "R9 sync packet");
        bus_wr(37, 2'd2, 32'h0);
        bus_wr(32, 2'd2, 32'h0);
        bus_rd(32, v); check(v == 3, "R5 relocked write ignored", v, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_packets();
        t_gating();
        measure_start(3);
        measure_start(7);
        t_fifo_full();
        t_sync();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule